// File: doc/BRIEF.md
# Saturating PI Regulator with Back-Calculation Anti-Windup

This block is the discrete proportional-integral stage of a sampled control loop, working on signed Q15 numbers where 32767 stands for just under +1.0 per unit. An output of +1.0 per unit means full duty when the result feeds a modulator. Each time the sample strobe is accepted, the block does four things in order. It forms the error as reference minus feedback. It adds the proportional term to the integrator value held from the previous step. It limits that sum to a window given at run time. It then updates the integrator with the scaled error plus a correction proportional to how far the limiter moved the output. The correction pulls the integrator back while the output is pinned, so it does not wind up.

Control is a two-state sequencer. **ST_IDLE** waits for a strobe. An accepted strobe (transition *accept*, ST_IDLE to ST_INTEG) registers the limited output, the error, the limiter difference and the integral and correction gains. **ST_INTEG** writes the new integrator value and always returns to ST_IDLE (transition *retire*). A synchronous clear forces ST_IDLE from either state (transition *abort*) and zeroes the integrator. The loop can therefore take one sample every two clock cycles, which is far above typical control rates of tens of kilohertz.

Top module: `pi_aw_ctrl`

## Requirements
- R1: After reset, u_out is 0, u_valid and busy are low, and the integrator holds 0.
- R2: The error is the reference minus the feedback, saturated to [-32768, 32767]. The unlimited output is U = sat(q(K0,E) + I), where I is the integrator value before this sample.
- R3: Every product q(a,b) is (a*b + 16384) shifted arithmetically right by 15 and then saturated, so that -32768 times -32768 gives 32767. Every sum saturates to [-32768, 32767] and never wraps.
- R4: On an accepted strobe, the output is min(max(U, u_min), u_max). It appears on u_out with u_valid high in the cycle after the strobe edge. u_valid stays high for exactly one cycle, and u_out holds its value until the next accepted strobe.
- R5: In the cycle after acceptance, the integrator becomes sat(I + q(K1,E) + q(Kc,Epi)), where Epi = sat(Usat - U). This is one saturation of the three-term sum. The next sample uses the new value.
- R6: When U lies inside [u_min, u_max], Epi is zero and only the K1 term changes the integrator, whatever the value of Kc.
- R7: busy is high in ST_INTEG. A strobe seen there is ignored: no u_valid, u_out unchanged, no second integrator update.
- R8: clear zeroes the integrator at the next edge and returns to ST_IDLE. This holds in either state and overrides a pending update. A strobe during clear is ignored.
- R9: K1 and Kc are captured at the accept edge. Changing them while busy has no effect on the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous integrator clear |
| sample | input | 1 | Sample strobe |
| ref_in | input | 16 | Reference, signed Q15 |
| fb_in | input | 16 | Measured feedback, signed Q15 |
| k0 | input | 16 | Proportional gain, signed Q15 |
| k1 | input | 16 | Integral gain, signed Q15 |
| kcorr | input | 16 | Anti-windup correction gain, signed Q15 |
| u_min | input | 16 | Lower output limit, signed Q15 |
| u_max | input | 16 | Upper output limit, signed Q15 |
| u_out | output | 16 | Limited output, signed Q15 |
| u_valid | output | 1 | One-cycle pulse marking a new u_out |
| busy | output | 1 | High while the integrator update is pending |

## Verification
The embedded assertions run on every cycle and check the framing of the sequencer. They confirm that u_valid is a single-cycle pulse, that no pulse follows a busy cycle, and that a published output lies within the limits given at the strobe. They also confirm that the integrator moves only in ST_INTEG and reads zero after a clear. Only the bench scenarios can show that the numbers are right. It checks the rounding and saturation of each product and sum, the back-calculation correction while the output is pinned, and the capture of the gains at acceptance. It exposes the integrator through a probing sample with zero proportional gain and an open output window.

// File: rtl/pi_aw_pkg.sv
package pi_aw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_INTEG = 1'b1
    } pi_state_e;
endpackage

// File: rtl/pi_sat.sv
// Narrows a signed value to OUT_W bits, clipping to the representable range.
module pi_sat #(
    parameter int IN_W  = 17,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  d,
    output logic signed [OUT_W-1:0] q
);
    localparam int PAD = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] HI = $signed({{PAD{1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] LO = $signed({{PAD{1'b1}}, {(OUT_W-1){1'b0}}});

    always_comb begin
        if (d > HI)      q = HI[OUT_W-1:0];
        else if (d < LO) q = LO[OUT_W-1:0];
        else             q = d[OUT_W-1:0];
    end
endmodule

// File: rtl/pi_qmul.sv
// Fixed-point multiply: full product, round half up at FRAC, saturate.
module pi_qmul #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;
    localparam logic signed [PW:0] HALF =
        $signed({{(PW+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}});

    logic signed [PW-1:0] prod;
    logic signed [PW:0]   rnd;
    logic signed [PW:0]   shr;

    always_comb begin
        prod = a * b;
        rnd  = $signed({prod[PW-1], prod}) + HALF;
        shr  = rnd >>> FRAC;
    end

    pi_sat #(.IN_W(PW+1), .OUT_W(W)) u_sat (.d(shr), .q(p));
endmodule

// File: rtl/pi_clamp.sv
// Output limiter plus the saturated limiter difference used for back-calculation.
module pi_clamp #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] u,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output logic signed [W-1:0] y,
    output logic signed [W-1:0] epi
);
    logic signed [W:0] diff;

    always_comb begin
        if (u > hi)      y = hi;
        else if (u < lo) y = lo;
        else             y = u;
        diff = $signed({y[W-1], y}) - $signed({u[W-1], u});
    end

    pi_sat #(.IN_W(W+1), .OUT_W(W)) u_sat (.d(diff), .q(epi));
endmodule

// File: rtl/pi_aw_ctrl.sv
module pi_aw_ctrl
    import pi_aw_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic signed [W-1:0] ref_in,
    input  logic signed [W-1:0] fb_in,
    input  logic signed [W-1:0] k0,
    input  logic signed [W-1:0] k1,
    input  logic signed [W-1:0] kcorr,
    input  logic signed [W-1:0] u_min,
    input  logic signed [W-1:0] u_max,
    output logic signed [W-1:0] u_out,
    output logic                u_valid,
    output logic                busy
);
    localparam int EW = W + 1;   // two-term sum width
    localparam int IW = W + 2;   // three-term sum width

    pi_state_e state_q, state_d;

    logic signed [W-1:0] integ_q, e_q, epi_q, k1_q, kc_q;
    logic signed [EW-1:0] err_w, u_w;
    logic signed [IW-1:0] i_w;
    logic signed [W-1:0] err, p0, u_raw, u_lim, epi, p1, p2, i_next;

    // ---------------- sample-path arithmetic ----------------
    assign err_w = $signed({ref_in[W-1], ref_in}) - $signed({fb_in[W-1], fb_in});
    pi_sat #(.IN_W(EW), .OUT_W(W)) u_err_sat (.d(err_w), .q(err));

    pi_qmul #(.W(W), .FRAC(FRAC)) u_mul_p (.a(k0), .b(err), .p(p0));

    assign u_w = $signed({p0[W-1], p0}) + $signed({integ_q[W-1], integ_q});
    pi_sat #(.IN_W(EW), .OUT_W(W)) u_u_sat (.d(u_w), .q(u_raw));

    pi_clamp #(.W(W)) u_lim_blk (
        .u(u_raw), .lo(u_min), .hi(u_max), .y(u_lim), .epi(epi)
    );

    // ---------------- integrator-path arithmetic ----------------
    pi_qmul #(.W(W), .FRAC(FRAC)) u_mul_i (.a(k1_q), .b(e_q),   .p(p1));
    pi_qmul #(.W(W), .FRAC(FRAC)) u_mul_c (.a(kc_q), .b(epi_q), .p(p2));

    assign i_w = $signed({{2{integ_q[W-1]}}, integ_q})
               + $signed({{2{p1[W-1]}}, p1})
               + $signed({{2{p2[W-1]}}, p2});
    pi_sat #(.IN_W(IW), .OUT_W(W)) u_i_sat (.d(i_w), .q(i_next));

    // ---------------- sequencer ----------------
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (sample) state_d = ST_INTEG;
                ST_INTEG: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- registered outputs and datapath state ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_out   <= '0;
            u_valid <= 1'b0;
            integ_q <= '0;
            e_q     <= '0;
            epi_q   <= '0;
            k1_q    <= '0;
            kc_q    <= '0;
        end else begin
            u_valid <= 1'b0;
            if (clear) begin
                integ_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (sample) begin
                            u_out   <= u_lim;
                            u_valid <= 1'b1;
                            e_q     <= err;
                            epi_q   <= epi;
                            k1_q    <= k1;
                            kc_q    <= kcorr;
                        end
                    end
                    ST_INTEG: integ_q <= i_next;
                    default: ;
                endcase
            end
        end
    end

    assign busy = (state_q == ST_INTEG);

    // ---------------- assertions ----------------
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        u_valid |=> !u_valid);

    assert_out_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && $past(u_min <= u_max)) |->
            (u_out >= $past(u_min) && u_out <= $past(u_max)));

    assert_busy_ignores_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !u_valid);

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (integ_q == '0));

    assert_integ_held_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !clear) |=> (integ_q == $past(integ_q)));
endmodule

// File: tb/sim_pi_aw_ctrl.sv
module sim_pi_aw_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic sample = 1'b0;
    logic signed [15:0] ref_in = '0, fb_in = '0, k0 = '0, k1 = '0, kcorr = '0;
    logic signed [15:0] u_min = '0, u_max = '0;
    logic signed [15:0] u_out;
    logic u_valid, busy;

    int n_chk = 0;
    int n_fail = 0;
    longint m_integ = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pi_aw_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample(sample),
        .ref_in(ref_in), .fb_in(fb_in), .k0(k0), .k1(k1), .kcorr(kcorr),
        .u_min(u_min), .u_max(u_max), .u_out(u_out), .u_valid(u_valid), .busy(busy)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint qm(input longint a, input longint b);
        longint p;
        p = a * b + 16384;
        return sat16(p >>> 15);
    endfunction

    function automatic longint rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'($signed(seed[31:16]));
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One accepted sample; optionally disturb K1/Kc while busy (R9).
    task automatic do_sample(input longint r, input longint f, input longint g0,
                             input longint g1, input longint gc,
                             input longint lo, input longint hi,
                             input bit swap_gain, input string tag);
        longint e, u, us, ep;
        @(negedge clk);
        ref_in = 16'(r); fb_in = 16'(f); k0 = 16'(g0); k1 = 16'(g1); kcorr = 16'(gc);
        u_min = 16'(lo); u_max = 16'(hi); sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        e  = sat16(r - f);
        u  = sat16(qm(g0, e) + m_integ);
        us = (u > hi) ? hi : ((u < lo) ? lo : u);
        ep = sat16(us - u);
        chk(longint'(u_out) == us, tag, longint'(u_out), us);
        chk(u_valid == 1'b1, "R4 valid", longint'(u_valid), 1);
        chk(busy == 1'b1, "R7 busy", longint'(busy), 1);
        if (swap_gain) begin
            k1 = 16'(g1 ^ 16'h5a5a);
            kcorr = 16'(gc ^ 16'h3c3c);
        end
        @(negedge clk);
        m_integ = sat16(m_integ + qm(g1, e) + qm(gc, ep));
        chk(u_valid == 1'b0, "R4 pulse", longint'(u_valid), 0);
    endtask

    // Reads the integrator back: zero P gain, E = 0, open window -> u_out = I.
    task automatic probe(input string tag);
        do_sample(0, 0, 0, 0, 0, -32768, 32767, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint a, b, hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(u_out == 16'sd0, "R1 u_out", longint'(u_out), 0);
        chk(u_valid == 1'b0, "R1 u_valid", longint'(u_valid), 0);
        chk(busy == 1'b0, "R1 busy", longint'(busy), 0);
        probe("R1 integ");

        // R2 / R3 directed arithmetic corners
        do_sample(32767, -32768, 32767, 0, 0, -32768, 32767, 1'b0, "R2 err sat");
        do_sample(1, 0, 16384, 0, 0, -32768, 32767, 1'b0, "R3 round up");
        do_sample(-1, 0, 16384, 0, 0, -32768, 32767, 1'b0, "R3 round half");
        do_sample(-32768, 0, -32768, 0, 0, -32768, 32767, 1'b0, "R3 prod sat");
        do_sample(1000, 300, 8192, 20000, 0, -32768, 32767, 1'b0, "R2 p+i");
        probe("R5 integ");
        do_sample(30000, -30000, 32767, 32767, 0, -32768, 32767, 1'b0, "R3 sum sat");
        do_sample(30000, -30000, 32767, 32767, 0, -32768, 32767, 1'b0, "R3 sum sat 2");
        probe("R3 integ sat");

        // R4 / R5 clamp with back-calculation
        do_sample(20000, 0, 32767, 16000, 16384, -1000, 2000, 1'b0, "R4 clamp hi");
        probe("R5 back-calc");
        do_sample(-20000, 0, 32767, 16000, 32767, -1500, 1500, 1'b0, "R4 clamp lo");
        probe("R5 back-calc lo");

        // R6: unclamped, big Kc has no influence
        hold = m_integ;
        do_sample(500, 200, 4000, 12000, 32767, -32768, 32767, 1'b0, "R6 open");
        chk(m_integ == sat16(hold + qm(12000, 300)), "R6 model", m_integ, sat16(hold + qm(12000, 300)));
        probe("R6 integ");

        // R9: gains changed while busy
        do_sample(4000, 1000, 2000, 9000, 20000, -500, 500, 1'b1, "R9 sample");
        probe("R9 integ");

        // R7: strobe held into busy cycle
        @(negedge clk);
        ref_in = 16'sd3000; fb_in = 16'sd0; k0 = 16'sd10000; k1 = 16'sd5000; kcorr = 16'sd0;
        u_min = -16'sd32768; u_max = 16'sd32767; sample = 1'b1;
        @(negedge clk);
        a = sat16(qm(10000, 3000) + m_integ);
        chk(longint'(u_out) == a, "R7 first", longint'(u_out), a);
        ref_in = 16'sd9000;
        @(negedge clk);
        sample = 1'b0;
        chk(u_valid == 1'b0, "R7 ignored", longint'(u_valid), 0);
        chk(longint'(u_out) == a, "R7 hold", longint'(u_out), a);
        m_integ = sat16(m_integ + qm(5000, 3000));
        probe("R7 single update");

        // R8: clear in idle with strobe, then clear during busy
        @(negedge clk);
        clear = 1'b1; sample = 1'b1;
        @(negedge clk);
        clear = 1'b0; sample = 1'b0;
        chk(u_valid == 1'b0, "R8 strobe ignored", longint'(u_valid), 0);
        m_integ = 0;
        probe("R8 cleared");
        do_sample(0, 0, 0, 0, 0, -32768, 32767, 1'b0, "R8 pre");
        do_sample(10000, 0, 0, 30000, 0, -32768, 32767, 1'b0, "R8 load");
        @(negedge clk);
        ref_in = 16'sd10000; fb_in = 16'sd0; k0 = 16'sd0; k1 = 16'sd30000; kcorr = 16'sd0;
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(busy == 1'b0, "R8 abort", longint'(busy), 0);
        m_integ = 0;
        probe("R8 busy clear");

        // Sweep: pseudo-random operands, limits and gains
        for (int i = 0; i < 300; i++) begin
            a = rnd16(); b = rnd16();
            do_sample(rnd16(), rnd16(), rnd16(), rnd16() >>> (i % 4), rnd16(),
                      (a < b) ? a : b, (a < b) ? b : a, i[0], "R4 sweep");
            if (i % 25 == 0) probe("R5 sweep integ");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule